// File: doc/BRIEF.md
# Timekeeping Divider with Interval Flag and Buzzer Tones

The block divides a slow timekeeping reference, nominally 32768 Hz, with a binary counter. The reference reaches the block as a one-cycle enable pulse (`ref_tick`) on the fast system clock. Fixed taps on this counter drive three outputs:

- a sticky interval flag, set every short period (2^SHORT_LOG2 ticks, 128 by default, about 3.9 ms) or every long period (2^LONG_LOG2 ticks, 16384 by default, 0.5 s);
- a square-wave buzzer tone at one of four rates (reference/16, /8, /4 or /2, which is 2, 4, 8 or 16 kHz at the nominal rate);
- a periodic one-cycle clock enable for a display controller.

A write strobe loads the configuration: interval length, tone selection and buzzer enable. Software acknowledges the flag with a write-one-to-clear pulse. A separate clear pulse restarts the divider from zero, so that the next interval is a full period. A new interval length waits for the boundary of the running period before it takes effect.

Top module: `watch_buzz_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_flag`, `buzz_out` and `disp_ce` are low. The divider is zero, the short interval is active and the buzzer is disabled.
- R2: The divider advances by exactly one on each clock with `ref_tick` high, and holds on every other clock.
- R3: In short mode `irq_flag` rises one clock after every tick that completes a multiple of 2^SHORT_LOG2 ticks since the divider was last zero.
- R4: In long mode `irq_flag` rises one clock after the tick that completes 2^LONG_LOG2 ticks.
- R5: `irq_flag` stays high until a `flag_clear` pulse. If a boundary falls in the same cycle as `flag_clear`, the flag is set.
- R6: When the buzzer is enabled, `buzz_out` equals divider bit (3 - tone). Tone code 0 gives reference/16, 1 gives /8, 2 gives /4 and 3 gives /2.
- R7: When the buzzer is disabled, `buzz_out` is low.
- R8: `disp_ce` is high for one clock after each tick that brings the low DISP_LOG2 divider bits back to zero.
- R9: `div_clear` sets the divider to zero. It overrides a tick in the same cycle, produces no boundary and no display enable in that cycle, and applies the pending interval length.
- R10: A `cfg_long` written through `cfg_wr` takes effect at the next boundary of the running interval. A switch from short to long restarts the divider at that boundary, so the first long period is full.
- R11: `cfg_tone` and `cfg_buz_en` take effect in the clock after the `cfg_wr` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_long | input | 1 | Interval length: 1 long, 0 short |
| cfg_tone | input | 2 | Buzzer tone code |
| cfg_buz_en | input | 1 | Buzzer output enable |
| div_clear | input | 1 | Restart divider from zero |
| flag_clear | input | 1 | Write-one-to-clear for the interval flag |
| irq_flag | output | 1 | Sticky interval flag |
| buzz_out | output | 1 | Buzzer square wave |
| disp_ce | output | 1 | Display controller clock enable |

## Verification
The bench builds the block with LONG_LOG2=8, SHORT_LOG2=4 and DISP_LOG2=3. With these values a long period lasts 256 ticks, so every interval, tone phase and display pulse wraps many times within a short run. All four tone codes are swept with the buzzer on and off, under dense and sparse tick patterns. Exact tick counts are measured across mode switches, clears and flag acknowledges that coincide with a boundary.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    localparam int TONE_CODES = 4;
    localparam int TONE_W     = $clog2(TONE_CODES);

    typedef struct packed {
        logic              long_sel;
        logic [TONE_W-1:0] tone;
        logic              buz_en;
    } wbt_cfg_t;

    // tone code 0 -> slowest tap (bit 3), code 3 -> fastest tap (bit 0)
    function automatic logic [TONE_W-1:0] tone_tap(input logic [TONE_W-1:0] code);
        return TONE_W'(TONE_CODES - 1) - code;
    endfunction

endpackage

// File: rtl/wbt_divider.sv
module wbt_divider #(
    parameter int CNT_W      = 14,
    parameter int SHORT_LOG2 = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic             pend_long,
    output logic [CNT_W-1:0] cnt,
    output logic             bnd,
    output logic             act_long
);

    logic long_end;
    logic short_end;

    assign long_end  = &cnt;
    assign short_end = &cnt[SHORT_LOG2-1:0];
    assign bnd       = tick && !clr && (act_long ? long_end : short_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_long <= 1'b0;
        end else if (clr) begin
            cnt      <= '0;
            act_long <= pend_long;
        end else if (bnd) begin
            act_long <= pend_long;
            if (pend_long && !act_long)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R10
    mode_only_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!bnd && !clr) |=> $stable(act_long));

endmodule

// File: rtl/wbt_events.sv
module wbt_events #(
    parameter int CNT_W     = 14,
    parameter int DISP_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             bnd,
    input  logic             flag_clear,
    output logic             flag,
    output logic             disp_ce
);

    logic disp_hit;
    assign disp_hit = tick && !clr && (&cnt[DISP_LOG2-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            disp_ce <= 1'b0;
        end else begin
            disp_ce <= disp_hit;
            if (bnd)
                flag <= 1'b1;
            else if (flag_clear)
                flag <= 1'b0;
        end
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        bnd |=> flag);

    // R5
    flag_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clear && !bnd) |=> !flag);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clear) |=> flag);

    // R8
    disp_single_chk: assert property (@(posedge clk) disable iff (rst)
        disp_ce |=> !disp_ce);

endmodule

// File: rtl/wbt_tone.sv
module wbt_tone
    import wbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  wbt_cfg_t cfg_in,
    input  logic [TONE_CODES-1:0] taps,
    output logic     pend_long,
    output logic     buzz
);

    wbt_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr)
            cfg_q <= cfg_in;
    end

    assign pend_long = cfg_q.long_sel;
    assign buzz      = cfg_q.buz_en & taps[tone_tap(cfg_q.tone)];

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg_q));

endmodule

// File: rtl/watch_buzz_timer.sv
module watch_buzz_timer
    import wbt_pkg::*;
#(
    parameter int LONG_LOG2  = 14,
    parameter int SHORT_LOG2 = 7,
    parameter int DISP_LOG2  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              cfg_wr,
    input  logic              cfg_long,
    input  logic [TONE_W-1:0] cfg_tone,
    input  logic              cfg_buz_en,
    input  logic              div_clear,
    input  logic              flag_clear,
    output logic              irq_flag,
    output logic              buzz_out,
    output logic              disp_ce
);

    localparam int CNT_W = LONG_LOG2;

    logic [CNT_W-1:0] cnt;
    logic             bnd;
    logic             act_long;
    logic             pend_long;
    wbt_cfg_t         cfg_in;

    assign cfg_in = '{long_sel: cfg_long, tone: cfg_tone, buz_en: cfg_buz_en};

    wbt_divider #(
        .CNT_W      (CNT_W),
        .SHORT_LOG2 (SHORT_LOG2)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick      (ref_tick),
        .clr       (div_clear),
        .pend_long (pend_long),
        .cnt       (cnt),
        .bnd       (bnd),
        .act_long  (act_long)
    );

    wbt_events #(
        .CNT_W     (CNT_W),
        .DISP_LOG2 (DISP_LOG2)
    ) u_evt (
        .clk        (clk),
        .rst        (rst),
        .tick       (ref_tick),
        .clr        (div_clear),
        .cnt        (cnt),
        .bnd        (bnd),
        .flag_clear (flag_clear),
        .flag       (irq_flag),
        .disp_ce    (disp_ce)
    );

    wbt_tone u_tone (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .cfg_in    (cfg_in),
        .taps      (cnt[TONE_CODES-1:0]),
        .pend_long (pend_long),
        .buzz      (buzz_out)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_flag && !buzz_out && !disp_ce));

    // R3
    short_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && !div_clear && !act_long && (&cnt[SHORT_LOG2-1:0])) |=> irq_flag);

endmodule

// File: tb/test_watch_buzz_timer.sv
module test_watch_buzz_timer;

    localparam int LL = 8;
    localparam int SL = 4;
    localparam int DL = 3;
    localparam logic [LL-1:0] LMAX = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0, cfg_wr = 1'b0, cfg_long = 1'b0, cfg_buz_en = 1'b0;
    logic [1:0] cfg_tone = 2'd0;
    logic div_clear = 1'b0, flag_clear = 1'b0;
    logic irq_flag, buzz_out, disp_ce;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    watch_buzz_timer #(.LONG_LOG2(LL), .SHORT_LOG2(SL), .DISP_LOG2(DL)) i_watch_buzz_timer (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_wr(cfg_wr),
        .cfg_long(cfg_long), .cfg_tone(cfg_tone), .cfg_buz_en(cfg_buz_en),
        .div_clear(div_clear), .flag_clear(flag_clear),
        .irq_flag(irq_flag), .buzz_out(buzz_out), .disp_ce(disp_ce)
    );

    // reference model, built from the requirements
    logic [LL-1:0] m_cnt;
    logic m_act, m_pend, m_flag, m_disp, m_en;
    logic [1:0] m_tone;

    always @(posedge clk) begin
        logic b;
        if (rst) begin
            m_cnt = '0; m_act = 0; m_pend = 0; m_flag = 0; m_disp = 0; m_en = 0; m_tone = 0;
        end else begin
            b = ref_tick && !div_clear &&
                (m_act ? (m_cnt == LMAX) : ((m_cnt % (1 << SL)) == (1 << SL) - 1));
            m_disp = ref_tick && !div_clear && ((m_cnt % (1 << DL)) == (1 << DL) - 1);
            if (b) m_flag = 1;
            else if (flag_clear) m_flag = 0;
            if (div_clear) begin
                m_cnt = '0; m_act = m_pend;
            end else if (b) begin
                m_cnt = (m_pend && !m_act) ? '0 : m_cnt + 1'b1;
                m_act = m_pend;
            end else if (ref_tick) begin
                m_cnt = m_cnt + 1'b1;
            end
            if (cfg_wr) begin
                m_pend = cfg_long; m_en = cfg_buz_en; m_tone = cfg_tone;
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive, advance, compare all outputs against the model
    task automatic cyc(input logic t);
        logic eb;
        ref_tick = t;
        @(posedge clk);
        @(negedge clk);
        ref_tick = 0; cfg_wr = 0; div_clear = 0; flag_clear = 0;
        eb = m_en ? m_cnt[3 - m_tone] : 1'b0;
        chk(m_en ? "R6 tone tap" : "R7 buzzer off", buzz_out, eb);
        chk(m_act ? "R4 long flag" : "R3 short flag", irq_flag, m_flag);
        chk("R8 display enable", disp_ce, m_disp);
    endtask

    task automatic write_cfg(input logic lg, input logic [1:0] tn, input logic en);
        cfg_wr = 1; cfg_long = lg; cfg_tone = tn; cfg_buz_en = en;
        cyc(0);
    endtask

    // acknowledge the flag, then count ticks until it rises again
    task automatic ticks_to_flag(output int n);
        flag_clear = 1;
        cyc(0);
        n = 0;
        while (!irq_flag && n < 1000) begin
            cyc(1);
            n++;
        end
    endtask

    initial begin
        int n;
        cfg_long = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 flag in reset", irq_flag, 1'b0);
        chk("R1 buzz in reset", buzz_out, 1'b0);
        chk("R1 disp in reset", disp_ce, 1'b0);
        rst = 0;
        cyc(1);
        chk("R1 buzzer disabled after reset", buzz_out, 1'b0);

        // R6 / R11: sweep all tones, dense ticks
        for (int t = 0; t < 4; t++) begin
            write_cfg(0, 2'(t), 1);
            for (int k = 0; k < 70; k++) cyc(1);
        end
        // R7: disabled, all tones
        for (int t = 0; t < 4; t++) begin
            write_cfg(0, 2'(t), 0);
            for (int k = 0; k < 20; k++) cyc(1);
        end

        // R3: exact short period after clear
        write_cfg(0, 2'd3, 1);
        div_clear = 1; flag_clear = 1;
        cyc(0);
        for (int k = 0; k < 15; k++) cyc(1);
        chk("R3 no flag before 16 ticks", irq_flag, 1'b0);
        cyc(1);
        chk("R3 flag after 16 ticks", irq_flag, 1'b1);

        // R5: sticky, then acknowledged
        for (int k = 0; k < 5; k++) cyc(0);
        chk("R5 flag held", irq_flag, 1'b1);
        flag_clear = 1;
        cyc(0);
        chk("R5 flag cleared", irq_flag, 1'b0);
        // R5: boundary coincident with clear
        for (int k = 0; k < 15; k++) cyc(1);
        flag_clear = 1;
        cyc(1);
        chk("R5 boundary beats clear", irq_flag, 1'b1);

        // R2: sparse ticks
        for (int k = 0; k < 300; k++) cyc(k % 3 == 0);
        for (int k = 0; k < 300; k++) cyc(k % 7 == 2);

        // R10: switch to long mid short period
        div_clear = 1;
        cyc(0);
        for (int k = 0; k < 5; k++) cyc(1);
        write_cfg(1, 2'd1, 1);
        ticks_to_flag(n);
        chk_int("R10 pending select waits for short edge", n, 11);
        ticks_to_flag(n);
        chk_int("R10 R4 first long period full", n, 256);
        ticks_to_flag(n);
        chk_int("R4 long period", n, 256);

        // R9: clear in long mode restarts a full period
        for (int k = 0; k < 100; k++) cyc(1);
        div_clear = 1; ref_tick = 1;
        cyc(1);
        ticks_to_flag(n);
        chk_int("R9 full period after clear", n, 256);

        // R10: back to short, takes effect at long edge
        for (int k = 0; k < 40; k++) cyc(1);
        write_cfg(0, 2'd2, 1);
        ticks_to_flag(n);
        chk_int("R10 long period completes first", n, 256 - 40);
        ticks_to_flag(n);
        chk_int("R3 short period after switch", n, 16);

        for (int k = 0; k < 200; k++) cyc(k % 2 == 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule